// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation tables held in main memory. A walk starts from a context table pointer and a context number. From there it follows descriptors through a region table, a segment table and a page table. Every fetched word carries a two-bit type tag in bits 1:0. The block checks that tag at each step, so that a broken chain ends in a fault that names the level where the walk stopped.

When the walk reaches the final entry, the block checks the requested access against a three-bit access code. That code holds the user and supervisor rights together. If the access is allowed, the block sets the referenced bit in the entry, and also the modified bit for writes, by writing the entry back to memory. It then reports the physical address and a cacheable flag. The memory side is a plain word port with one request in flight at a time. A caller raises a request while the walker is idle and waits for either a done pulse or a fault pulse.

Top module: `pgwalk`

## Requirements
- R1: A request (`req_valid` high) is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance up to and including the result pulse. A request raised while `busy` is high is ignored and starts no memory access.
- R2: The first read is the context entry, at address `{ctx_ptr[31:6], ctx_num[3:0], 2'b00}`. The low six bits of `ctx_ptr` are ignored.
- R3: Bits 1:0 of every fetched word are its type: 0 invalid, 1 descriptor, 2 page entry, 3 reserved. A context, region or segment word whose type is not 1 ends the walk with `fault_code` 1, 2 or 3 respectively. No further memory access is made after that word.
- R4: Each next table base is the descriptor with bits 1:0 cleared and shifted left by four, truncated to 32 bits. The entry address is that base ORed with the index times four. The region index is VA[31:24], the segment index is VA[23:18] and the page index is VA[17:12].
- R5: A page-level word whose type is not 2 ends the walk with `fault_code` 4.
- R6: For a page entry, the access code is bits 4:2. A user-mode access (`req_user`=1) to an entry with code 6 or 7 ends the walk with `fault_code` 5. Every other read is permitted.
- R7: A write is permitted for codes 1 and 3 in both modes, and for codes 5 and 7 only in supervisor mode. Any other write ends the walk with `fault_code` 5.
- R8: A permitted walk writes the entry back to the page entry address with bit 5 (referenced) set, and also bit 6 (modified) set when the access is a write. With the default `SKIP_CLEAN_WB`=1, the write-back is left out when those bits are already set. A faulting walk never writes.
- R9: On success, `done_pa` (36 bits) is `{entry[31:8], VA[11:0]}` and `done_cacheable` is entry bit 7.
- R10: `done_valid` and `fault_valid` are single-cycle pulses and are never high together. The cycle after either pulse, `busy` is low. `fault_code` is 0 whenever `fault_valid` is low.
- R11: At most one memory request is outstanding. `mem_req` together with `mem_addr`, `mem_we` and `mem_wdata` is held until the cycle in which `mem_ack` is high. A walk makes its reads strictly in the order context, region, segment, page, followed by at most one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| ctx_num | input | CTX_W (4) | Context number |
| ctx_ptr | input | ADDR_W (32) | Context table pointer, 64-byte aligned |
| busy | output | 1 | Walk in progress |
| done_valid | output | 1 | Translation result pulse |
| done_pa | output | 36 | Physical address, valid with done_valid |
| done_cacheable | output | 1 | Cacheable flag, valid with done_valid |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 3 | 1 context, 2 region, 3 segment, 4 page type, 5 protection |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W (32) | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Two situations are the hardest to reach from the ports. The first is a protection fault, or a skipped write-back, that comes only after three good descriptors. The second is a second request that arrives while a walk is already running. For every walk the bench builds a fresh, sparse table set in its memory model, with separately chosen type tags for each level and a chosen page entry. It then sweeps every stop level, every access code in both modes for reads and writes, and every preset state of the referenced and modified bits. In every walk it raises a stray request one cycle after acceptance and then counts the memory accesses, to confirm that the stray request leaves no trace.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   localparam int unsigned VA_W      = 32;
   localparam int unsigned ENT_W     = 32;
   localparam int unsigned OFF_W     = 12;
   localparam int unsigned PG_LSB    = 12;
   localparam int unsigned PG_IDX_W  = 6;
   localparam int unsigned SEG_LSB   = 18;
   localparam int unsigned SEG_IDX_W = 6;
   localparam int unsigned REG_LSB   = 24;
   localparam int unsigned REG_IDX_W = 8;
   localparam int unsigned PPN_LSB   = 8;
   localparam int unsigned PPN_W     = ENT_W - PPN_LSB;
   localparam int unsigned PA_W      = PPN_W + OFF_W;
   localparam int unsigned BASE_SH   = 4;

   localparam int unsigned BIT_CACHE = 7;
   localparam int unsigned BIT_MOD   = 6;
   localparam int unsigned BIT_REF   = 5;
   localparam int unsigned ACC_LSB   = 2;
   localparam int unsigned ACC_W     = 3;

   localparam logic [1:0] TAG_INVALID = 2'd0;
   localparam logic [1:0] TAG_DESC    = 2'd1;
   localparam logic [1:0] TAG_LEAF    = 2'd2;
   localparam logic [1:0] TAG_RSVD    = 2'd3;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_CTX,
      WS_REGION,
      WS_SEGMENT,
      WS_PAGE,
      WS_WRITEBACK,
      WS_DONE,
      WS_FAULT
   } walk_state_e;

   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_CTX     = 3'd1,
      FC_REGION  = 3'd2,
      FC_SEGMENT = 3'd3,
      FC_PAGE    = 3'd4,
      FC_PROT    = 3'd5
   } fault_e;

endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CTX_W  = 4
) (
   input  walk_state_e        state,
   input  logic [ADDR_W-1:0]  ctx_ptr,
   input  logic [CTX_W-1:0]   ctx_num,
   input  logic [VA_W-1:0]    va,
   input  logic [ENT_W-1:0]   desc,
   output logic [ADDR_W-1:0]  addr
);

   localparam int CTX_SH   = CTX_W + 2;
   localparam int WIDE_W   = ENT_W + BASE_SH;

   logic [ADDR_W-1:0] ctx_addr;
   logic [ADDR_W-1:0] tbl_base;
   logic [ADDR_W-1:0] idx_off;
   logic [ADDR_W-1:0] ctx_mask;

   if (ADDR_W > WIDE_W) begin : g_bad_addr_w
      $error("pgwalk_addr_gen: ADDR_W exceeds the reach of a descriptor");
   end

   assign ctx_mask = ~ADDR_W'((64'd1 << CTX_SH) - 64'd1);
   assign ctx_addr = (ctx_ptr & ctx_mask) | (ADDR_W'(ctx_num) << 2);
   assign tbl_base = ADDR_W'({desc & ~ENT_W'(3), BASE_SH'(0)});

   always_comb begin
      unique case (state)
         WS_REGION:  idx_off = ADDR_W'(va[REG_LSB +: REG_IDX_W]) << 2;
         WS_SEGMENT: idx_off = ADDR_W'(va[SEG_LSB +: SEG_IDX_W]) << 2;
         default:    idx_off = ADDR_W'(va[PG_LSB  +: PG_IDX_W])  << 2;
      endcase
   end

   assign addr = (state == WS_CTX) ? ctx_addr : (tbl_base | idx_off);

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
#(
   parameter int CODE_W = ACC_W
) (
   input  logic [CODE_W-1:0] acc,
   input  logic              user,
   input  logic              write,
   output logic              allow
);

   logic user_barred;
   logic write_grant;

   if (CODE_W != 3) begin : g_bad_code_w
      $error("pgwalk_perm: access code must be three bits wide");
   end

   // codes 6,7: no user rights at all
   assign user_barred = user & acc[2] & acc[1];
   // odd codes carry write; upper half of the odd codes only for supervisor
   assign write_grant = acc[0] & (~acc[2] | ~user);
   assign allow       = ~user_barred & (~write | write_grant);

endmodule

// File: rtl/pgwalk_wb_merge.sv
module pgwalk_wb_merge
   import pgwalk_pkg::*;
#(
   parameter bit SKIP_CLEAN_WB = 1'b1
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             write,
   output logic [ENT_W-1:0] merged,
   output logic             need_wb
);

   logic [ENT_W-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      set_mask[BIT_REF] = 1'b1;
      set_mask[BIT_MOD] = write;
   end

   assign merged = entry | set_mask;

   if (SKIP_CLEAN_WB) begin : g_skip_clean
      assign need_wb = (merged != entry);
   end else begin : g_always_wb
      assign need_wb = 1'b1;
   end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
   import pgwalk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        mem_ack,
   input  logic [1:0]  ent_tag,
   input  logic        allow,
   input  logic        need_wb,
   output walk_state_e state,
   output fault_e      fault_q
);

   walk_state_e state_d;
   fault_e      fault_d;

   always_comb begin
      state_d = state;
      fault_d = fault_q;
      unique case (state)
         WS_IDLE: begin
            fault_d = FC_NONE;
            if (req_valid) state_d = WS_CTX;
         end
         WS_CTX: if (mem_ack) begin
            if (ent_tag == TAG_DESC) state_d = WS_REGION;
            else begin state_d = WS_FAULT; fault_d = FC_CTX; end
         end
         WS_REGION: if (mem_ack) begin
            if (ent_tag == TAG_DESC) state_d = WS_SEGMENT;
            else begin state_d = WS_FAULT; fault_d = FC_REGION; end
         end
         WS_SEGMENT: if (mem_ack) begin
            if (ent_tag == TAG_DESC) state_d = WS_PAGE;
            else begin state_d = WS_FAULT; fault_d = FC_SEGMENT; end
         end
         WS_PAGE: if (mem_ack) begin
            if (ent_tag != TAG_LEAF) begin
               state_d = WS_FAULT; fault_d = FC_PAGE;
            end else if (!allow) begin
               state_d = WS_FAULT; fault_d = FC_PROT;
            end else if (need_wb) begin
               state_d = WS_WRITEBACK;
            end else begin
               state_d = WS_DONE;
            end
         end
         WS_WRITEBACK: if (mem_ack) state_d = WS_DONE;
         WS_DONE:  state_d = WS_IDLE;
         WS_FAULT: state_d = WS_IDLE;
         default:  state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         fault_q <= FC_NONE;
      end else begin
         state   <= state_d;
         fault_q <= fault_d;
      end
   end

   // R3: a descriptor level never jumps straight to a result
   a_r3_level_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_REGION && mem_ack && ent_tag == TAG_DESC) |=> (state == WS_SEGMENT));

endmodule

// File: rtl/pgwalk.sv
module pgwalk
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int CTX_W         = 4,
   parameter bit SKIP_CLEAN_WB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [31:0]        req_va,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [CTX_W-1:0]   ctx_num,
   input  logic [ADDR_W-1:0]  ctx_ptr,
   output logic               busy,
   output logic               done_valid,
   output logic [35:0]        done_pa,
   output logic               done_cacheable,
   output logic               fault_valid,
   output logic [2:0]         fault_code,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata
);

   if (ADDR_W < 16 || ADDR_W > 36) begin : g_bad_addr
      $error("pgwalk: ADDR_W out of range");
   end
   if (CTX_W < 1 || CTX_W > 8) begin : g_bad_ctx
      $error("pgwalk: CTX_W out of range");
   end
   if (PA_W != 36 || VA_W != 32) begin : g_bad_layout
      $error("pgwalk: entry layout does not match port widths");
   end

   walk_state_e         state;
   fault_e              fault_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic                usr_q;
   logic [CTX_W-1:0]    ctx_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [ENT_W-1:0]    desc_q;
   logic [ENT_W-1:0]    pte_q;
   logic [ENT_W-1:0]    leaf_src;
   logic [ENT_W-1:0]    merged;
   logic                need_wb;
   logic                allow;
   logic                accept;
   logic                in_table;

   assign accept   = (state == WS_IDLE) && req_valid;
   assign in_table = (state == WS_CTX) || (state == WS_REGION) || (state == WS_SEGMENT);
   assign leaf_src = (state == WS_PAGE) ? mem_rdata : pte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q   <= '0;
         wr_q   <= 1'b0;
         usr_q  <= 1'b0;
         ctx_q  <= '0;
         ptr_q  <= '0;
         desc_q <= '0;
         pte_q  <= '0;
      end else begin
         if (accept) begin
            va_q  <= req_va;
            wr_q  <= req_write;
            usr_q <= req_user;
            ctx_q <= ctx_num;
            ptr_q <= ctx_ptr;
         end
         if (in_table && mem_ack) desc_q <= mem_rdata;
         if (state == WS_PAGE && mem_ack) pte_q <= mem_rdata;
      end
   end

   pgwalk_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mem_ack   (mem_ack),
      .ent_tag   (mem_rdata[1:0]),
      .allow     (allow),
      .need_wb   (need_wb),
      .state     (state),
      .fault_q   (fault_q)
   );

   pgwalk_addr_gen #(
      .ADDR_W (ADDR_W),
      .CTX_W  (CTX_W)
   ) u_addr (
      .state   (state),
      .ctx_ptr (ptr_q),
      .ctx_num (ctx_q),
      .va      (va_q),
      .desc    (desc_q),
      .addr    (mem_addr)
   );

   pgwalk_perm u_perm (
      .acc   (leaf_src[ACC_LSB +: ACC_W]),
      .user  (usr_q),
      .write (wr_q),
      .allow (allow)
   );

   pgwalk_wb_merge #(
      .SKIP_CLEAN_WB (SKIP_CLEAN_WB)
   ) u_merge (
      .entry   (leaf_src),
      .write   (wr_q),
      .merged  (merged),
      .need_wb (need_wb)
   );

   assign busy           = (state != WS_IDLE);
   assign mem_req        = in_table || (state == WS_PAGE) || (state == WS_WRITEBACK);
   assign mem_we         = (state == WS_WRITEBACK);
   assign mem_wdata      = mem_we ? merged : '0;
   assign done_valid     = (state == WS_DONE);
   assign fault_valid    = (state == WS_FAULT);
   assign fault_code     = fault_valid ? fault_q : FC_NONE;
   assign done_pa        = done_valid ? {pte_q[PPN_LSB +: PPN_W], va_q[OFF_W-1:0]} : '0;
   assign done_cacheable = done_valid & pte_q[BIT_CACHE];

   a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && fault_valid));

   a_r10_pulse_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid || fault_valid) |=> (!busy && !done_valid && !fault_valid));

   a_r1_busy_ends_on_result: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done_valid || fault_valid));

   a_r8_ref_written: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[BIT_REF] && (mem_wdata[BIT_MOD] || !wr_q)));

   a_r6_no_user_on_sup_only: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !(usr_q && pte_q[ACC_LSB+2] && pte_q[ACC_LSB+1]));

endmodule

// File: tb/pgwalk_tb_top.sv
`timescale 1ns/1ps
module pgwalk_tb_top;

   localparam logic [31:0] CTXP = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [31:0] req_va;
   logic        req_write;
   logic        req_user;
   logic [3:0]  ctx_num;
   logic [31:0] ctx_ptr;
   logic        busy, done_valid, done_cacheable, fault_valid;
   logic [35:0] done_pa;
   logic [2:0]  fault_code;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] mem [logic [31:0]];
   int          mem_lat = 0;
   int          wait_cnt = 0;
   logic [31:0] log_addr [8];
   logic        log_we   [8];
   logic [31:0] log_wd   [8];
   int          log_cnt = 0;

   always #2.5 clk = ~clk;

   pgwalk dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_va (req_va), .req_write (req_write),
      .req_user (req_user), .ctx_num (ctx_num), .ctx_ptr (ctx_ptr),
      .busy (busy), .done_valid (done_valid), .done_pa (done_pa),
      .done_cacheable (done_cacheable), .fault_valid (fault_valid),
      .fault_code (fault_code), .mem_req (mem_req), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_ack (mem_ack),
      .mem_rdata (mem_rdata)
   );

   // memory model: one request at a time, ack after mem_lat idle negedges
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req && rst_n) begin
            if (wait_cnt < mem_lat) begin
               wait_cnt++;
            end else begin
               wait_cnt = 0;
               if (log_cnt < 8) begin
                  log_addr[log_cnt] = mem_addr;
                  log_we[log_cnt]   = mem_we;
                  log_wd[log_cnt]   = mem_wdata;
               end
               log_cnt++;
               if (mem_we) mem[mem_addr] = mem_wdata;
               else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               mem_ack = 1'b1;
            end
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      summary();
      $finish;
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // rights table written as {user read, user write, sup read, sup write}
   function automatic bit perm_ok(input logic [2:0] code, input bit usr, input bit wr);
      logic [3:0] r;
      case (code)
         3'd0: r = 4'b1010;
         3'd1: r = 4'b1111;
         3'd2: r = 4'b1010;
         3'd3: r = 4'b1111;
         3'd4: r = 4'b1010;
         3'd5: r = 4'b1011;
         3'd6: r = 4'b0010;
         default: r = 4'b0011;
      endcase
      if (usr) return wr ? r[2] : r[3];
      return wr ? r[0] : r[1];
   endfunction

   task automatic run_walk(input logic [31:0] va, input logic [3:0] ctx,
                           input bit wr, input bit usr,
                           input logic [1:0] t_ctx, input logic [1:0] t_reg,
                           input logic [1:0] t_seg, input logic [31:0] pte,
                           input int lat);
      logic [31:0] exp_addr [4];
      int          exp_reads;
      int          exp_fc;
      bit          exp_done;
      logic [31:0] newp;
      bit          exp_wr;
      int          n;
      bit          got_done, got_fault;
      logic [2:0]  got_fc;
      logic [35:0] got_pa;
      logic        got_c;

      mem.delete();
      exp_addr[0] = CTXP | (32'(ctx) << 2);
      exp_addr[1] = 32'h0002_0000 | (32'(va[31:24]) << 2);
      exp_addr[2] = 32'h0003_0000 | (32'(va[23:18]) << 2);
      exp_addr[3] = 32'h0004_0000 | (32'(va[17:12]) << 2);
      mem[exp_addr[0]] = 32'h0000_2000 | 32'(t_ctx);
      mem[exp_addr[1]] = 32'h0000_3000 | 32'(t_reg);
      mem[exp_addr[2]] = 32'h0000_4000 | 32'(t_seg);
      mem[exp_addr[3]] = pte;

      exp_done = 1'b0; exp_wr = 1'b0;
      newp = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (t_ctx != 2'd1)        begin exp_fc = 1; exp_reads = 1; end
      else if (t_reg != 2'd1)   begin exp_fc = 2; exp_reads = 2; end
      else if (t_seg != 2'd1)   begin exp_fc = 3; exp_reads = 3; end
      else if (pte[1:0] != 2'd2) begin exp_fc = 4; exp_reads = 4; end
      else if (!perm_ok(pte[4:2], usr, wr)) begin exp_fc = 5; exp_reads = 4; end
      else begin exp_fc = 0; exp_reads = 4; exp_done = 1'b1; exp_wr = (newp != pte); end

      log_cnt = 0; wait_cnt = 0; mem_lat = lat;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr; ctx_num = ctx;
      @(negedge clk);
      // R1: stray request while busy must be ignored
      req_va = 32'hFFFF_F000; req_write = 1'b1; req_user = 1'b0; ctx_num = ~ctx;
      chk("R1", "busy after accept", 64'(busy), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!(done_valid || fault_valid) && n < 400) begin
         @(negedge clk);
         n++;
      end
      got_done = done_valid; got_fault = fault_valid; got_fc = fault_code;
      got_pa = done_pa; got_c = done_cacheable;

      chk(exp_done ? "R9" : (exp_fc == 5 ? "R6/R7" : "R3/R5"), "done", 64'(got_done), 64'(exp_done));
      chk("R10", "fault pulse", 64'(got_fault), 64'(!exp_done));
      chk(exp_fc == 4 ? "R5" : (exp_fc == 5 ? "R7" : "R3"), "fault_code", 64'(got_fc), 64'(exp_fc));
      if (exp_done) begin
         chk("R9", "pa", 64'(got_pa), 64'({pte[31:8], va[11:0]}));
         chk("R9", "cacheable", 64'(got_c), 64'(pte[7]));
      end
      @(negedge clk);
      chk("R10", "pulse over and idle", 64'({busy, done_valid, fault_valid}), 64'd0);
      repeat (4) @(negedge clk);
      chk("R1", "no access after walk", 64'(mem_req), 64'd0);
      chk("R11", "access count", 64'(log_cnt), 64'(exp_reads + (exp_wr ? 1 : 0)));
      for (int i = 0; i < exp_reads && i < log_cnt; i++) begin
         chk(i == 0 ? "R2" : "R4", "read address", 64'({log_we[i], log_addr[i]}), 64'({1'b0, exp_addr[i]}));
      end
      if (exp_wr && log_cnt == exp_reads + 1) begin
         chk("R8", "writeback addr/data", {log_addr[exp_reads], log_wd[exp_reads]}, {exp_addr[3], newp});
         chk("R8", "writeback is write", 64'(log_we[exp_reads]), 64'd1);
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0;
      req_user = 1'b0; ctx_num = '0; ctx_ptr = CTXP | 32'h3F;
      repeat (4) @(negedge clk);
      chk("R10", "reset outputs", 64'({busy, done_valid, fault_valid, fault_code, mem_req, mem_we}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", 64'({busy, mem_req}), 64'd0);

      // every context number, valid chain, varied addresses and latency
      for (int c = 0; c < 16; c++) begin
         logic [31:0] va;
         va = (32'(c) * 32'h9E37_79B9) ^ 32'h1234_5ABC;
         run_walk(va, 4'(c), c[0], 1'b0, 2'd1, 2'd1, 2'd1,
                  32'hA5C3_E000 | 32'(c << 8) | 32'h80 | (3 << 2) | 2, c % 3);
      end

      // bad tag at each descriptor level (R3) and at the page level (R5)
      for (int lvl = 0; lvl < 4; lvl++) begin
         for (int t = 0; t < 4; t++) begin
            logic [1:0] tc, tr, ts;
            logic [31:0] p;
            tc = 2'd1; tr = 2'd1; ts = 2'd1; p = 32'h1234_5600 | (3 << 2) | 2;
            if (lvl == 0) tc = 2'(t);
            if (lvl == 1) tr = 2'(t);
            if (lvl == 2) ts = 2'(t);
            if (lvl == 3) p = (p & ~32'h3) | 32'(t);
            if ((lvl < 3 && t == 1) || (lvl == 3 && t == 2)) continue;
            run_walk(32'hC0FF_EE00 + 32'(lvl * 4 + t) * 32'h0104_1000, 4'(lvl + t),
                     1'b0, 1'b1, tc, tr, ts, p, t & 1);
         end
      end

      // every access code in both modes for reads and writes (R6, R7, R8)
      for (int code = 0; code < 8; code++) begin
         for (int m = 0; m < 4; m++) begin
            run_walk(32'h7654_3210 ^ 32'(code * 32'h0041_3000 + m * 32'h0100_0111),
                     4'(code), m[0], m[1], 2'd1, 2'd1, 2'd1,
                     32'h00AB_CD00 | 32'(code << 2) | 32'((code & 1) << 7) | 2, m);
         end
      end

      // referenced/modified already set: write-back skipped or kept (R8)
      run_walk(32'h0012_3456, 4'd3, 1'b0, 1'b0, 2'd1, 2'd1, 2'd1, 32'hFFFF_FF00 | 32'h20 | (3 << 2) | 2, 0);
      run_walk(32'h0012_3456, 4'd3, 1'b1, 1'b0, 2'd1, 2'd1, 2'd1, 32'h0000_0100 | 32'h60 | (1 << 2) | 2, 1);
      run_walk(32'h0012_3456, 4'd3, 1'b1, 1'b0, 2'd1, 2'd1, 2'd1, 32'h0000_0100 | 32'h20 | (1 << 2) | 2, 2);
      run_walk(32'hFFFF_FFFF, 4'd15, 1'b0, 1'b1, 2'd1, 2'd1, 2'd1, 32'h0000_0000 | 32'h40 | (0 << 2) | 2, 0);

      summary();
      $finish;
   end

endmodule